// File: doc/BRIEF.md
# Recirculating Serial Byte Link

This block moves one byte across a single serial wire between two 8-bit shift registers clocked from the same edge. A start pulse copies a parallel byte into the sending register. Over the next eight clock cycles that register puts its top bit on the serial line. On each shift it rotates that top bit back into its bottom position, so the byte it holds is the same again when the transfer ends.

The receiving register has no parallel input. Its only data input is the serial line. Each arriving bit enters at its top position, and the bits already held move toward bit 0. The first bit sent therefore ends in bit 0, and the receiving register holds the byte in bit-reversed order. A sequencer counts the shifts, freezes both registers after the eighth one, and raises a completion flag. Downstream logic reads the received byte only while that flag is high.

The reset input is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `serlink_recirc`

## Requirements
- R1: While reset is asserted and after it is released, the send word, the receive word, the serial line and the completion flag are all zero.
- R2: A start pulse while no transfer is running loads the parallel byte into the send word, and the send word shows it in the next cycle.
- R3: The serial line equals send bit 7. Starting in the cycle after the load, it presents the loaded byte from bit 7 down to bit 0, one bit per cycle.
- R4: After the eighth shift the send word again equals the loaded byte.
- R5: After the eighth shift the receive word equals the loaded byte bit-reversed (receive bit i = loaded bit 7-i). For example, 8'b10110101 is received as 8'b10101101.
- R6: The completion flag is low for the eight shift cycles after the load, rises after exactly the eighth shift, and stays high until the next accepted start.
- R7: While no transfer is running, the send word, the receive word and the serial line hold their values.
- R8: A start pulse during a running transfer is ignored. The send word is not reloaded and the shift count is not restarted.
- R9: An accepted start clears the completion flag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both registers and the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle request to load and send a byte |
| load_data_i | input | 8 | Byte copied into the send register on an accepted start |
| serial_o | output | 1 | Serial line, the top bit of the send register |
| tx_word_o | output | 8 | Current contents of the send register |
| rx_word_o | output | 8 | Current contents of the receive register |
| done_o | output | 1 | High once eight shifts have completed; marks rx_word_o valid |

## Verification
The transfer is exercised with the asymmetric byte 8'b10110101, all-zeros, all-ones, single-bit bytes at each end, and an alternating pattern. The asymmetric and single-bit bytes show whether the received byte is reversed or not, and whether the rotation direction is right. All-ones after all-zeros shows that each bit position is overwritten. A start pulse injected partway through a transfer separates a design that ignores it from one that reloads or restarts the count. Stability is checked for several cycles after completion, which exposes any shift past the eighth.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/serlink_sequencer.sv
module serlink_sequencer
  import serlink_pkg::*;
#(
  parameter int unsigned BITS = 8,
  localparam int unsigned CW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign load_o  = start_i && (state_q == SQ_IDLE);
  assign shift_o = (state_q == SQ_SHIFT);
  assign done_o  = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (load_o) begin
      state_d = SQ_SHIFT;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else if (shift_o) begin
      if (cnt_q == LAST) begin
        state_d = SQ_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // R2 / R9: an accepted start arms a fresh count and drops done
  p_start_arms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == SQ_IDLE) |=> (state_q == SQ_SHIFT && cnt_q == '0 && !done_q));

  // R8: start while shifting does not restart the count
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == SQ_SHIFT && cnt_q != LAST) |=>
      (state_q == SQ_SHIFT && cnt_q == CW'($past(cnt_q) + 1'b1)));

  // R6: done holds until a start arrives
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);

  // R6: done rises only at the end of the last shift
  p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state_q) == SQ_SHIFT && $past(cnt_q) == LAST));

  // R7: done and an active shift never coexist
  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && state_q == SQ_SHIFT));
endmodule

// File: rtl/serlink_tx_rotator.sv
module serlink_tx_rotator #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o,
  output logic         msb_o
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_i)       word_d = data_i;
    else if (shift_i) word_d = {word_q[W-2:0], word_q[W-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;
  assign msb_o  = word_q[W-1];

  // R4: every shift moves the top bit into bit 0 and nothing is lost
  p_rotate_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> ($countones(word_q) == $countones($past(word_q))
                              && word_q[0] == $past(word_q[W-1])));

  // R2: a load presents the byte next cycle
  p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> word_q == $past(data_i));
endmodule

// File: rtl/serlink_rx_assembler.sv
module serlink_rx_assembler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_i) word_d = {ser_i, word_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

  // R5: each serial bit enters at the top
  p_enter_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> word_q[W-1] == $past(ser_i));

  // R7: no shift, no change
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(word_q));
endmodule

// File: rtl/serlink_recirc.sv
module serlink_recirc #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              serial_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       load_en;
  logic       shift_en;
  logic       ser_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  serlink_sequencer #(.BITS(DATA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .load_o  (load_en),
    .shift_o (shift_en),
    .done_o  (done_o)
  );

  serlink_tx_rotator #(.W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load_en),
    .shift_i (shift_en),
    .data_i  (load_data_i),
    .word_o  (tx_word_o),
    .msb_o   (ser_line)
  );

  serlink_rx_assembler #(.W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .shift_i (shift_en),
    .ser_i   (ser_line),
    .word_o  (rx_word_o)
  );

  assign serial_o = ser_line;

  // R6: receive word is frozen while done is high and no new start
  p_rx_frozen_done_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !start_i) |=> $stable(rx_word_o));
endmodule

// File: tb/serlink_recirc_test.sv
module serlink_recirc_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] load_data_i;
  logic       serial_o;
  logic [7:0] tx_word_o;
  logic [7:0] rx_word_o;
  logic       done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  serlink_recirc #(.DATA_W(8)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .load_data_i (load_data_i),
    .serial_o    (serial_o),
    .tx_word_o   (tx_word_o),
    .rx_word_o   (rx_word_o),
    .done_o      (done_o)
  );

  typedef struct {
    logic [7:0] tx;
    logic [7:0] rx;
  } result_t;

  logic    exp_bits[$];
  result_t exp_res[$];
  int      checks = 0;
  int      errors = 0;
  logic    prev_done = 1'b0;
  logic    mon_on = 1'b0;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  // monitor: compares serial bits and completed results against the queues
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_bits.size() > 0) begin
        logic b;
        b = exp_bits.pop_front();
        check(serial_o === b, "R3", "serial bit", 32'(serial_o), 32'(b));
      end
      if (done_o && !prev_done) begin
        if (exp_res.size() > 0) begin
          result_t r;
          r = exp_res.pop_front();
          check(tx_word_o === r.tx, "R4", "send word restored", 32'(tx_word_o), 32'(r.tx));
          check(rx_word_o === r.rx, "R5", "receive word reversed", 32'(rx_word_o), 32'(r.rx));
        end else begin
          check(1'b0, "R6", "unexpected done rise", 32'(done_o), 32'(0));
        end
      end
      prev_done = done_o;
    end
  end

  // driver: one transfer, optionally with a stray start mid-way
  task automatic xfer(input logic [7:0] d, input logic poke, input logic [7:0] pd);
    logic [7:0] s_tx, s_rx;
    logic       s_ser;
    @(negedge clk);
    start_i = 1'b1;
    load_data_i = d;
    @(posedge clk);
    #1;
    start_i = 1'b0;
    load_data_i = 8'h00;
    for (int i = 7; i >= 0; i--) exp_bits.push_back(d[i]);
    exp_res.push_back('{tx: d, rx: rev8(d)});
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        check(tx_word_o === d, "R2", "load into send word", 32'(tx_word_o), 32'(d));
        check(done_o === 1'b0, "R9", "done cleared by start", 32'(done_o), 32'(0));
      end
      if (poke && k == 3) begin
        start_i = 1'b1;
        load_data_i = pd;
      end
      if (k == 4) begin
        start_i = 1'b0;
        load_data_i = 8'h00;
        if (poke) begin
          logic [7:0] rot;
          rot = {d[4:0], d[7:5]};
          check(tx_word_o === rot, "R8", "no reload mid-transfer", 32'(tx_word_o), 32'(rot));
        end
      end
      if (k == 8)
        check(done_o === 1'b0, "R6", "done low before eighth shift", 32'(done_o), 32'(0));
    end
    @(negedge clk);
    check(done_o === 1'b1, "R6", "done after eighth shift", 32'(done_o), 32'(1));
    s_tx = tx_word_o;
    s_rx = rx_word_o;
    s_ser = serial_o;
    repeat (4) @(negedge clk);
    check(tx_word_o === s_tx && rx_word_o === s_rx && serial_o === s_ser,
          "R7", "idle hold", {8'h0, tx_word_o, rx_word_o, 7'h0, serial_o},
          {8'h0, s_tx, s_rx, 7'h0, s_ser});
    check(done_o === 1'b1, "R6", "done stays high", 32'(done_o), 32'(1));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    load_data_i = 8'h00;
    repeat (3) @(negedge clk);
    check({tx_word_o, rx_word_o, serial_o, done_o} === 18'h0, "R1", "reset state",
          32'({tx_word_o, rx_word_o, serial_o, done_o}), 32'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({tx_word_o, rx_word_o, serial_o, done_o} === 18'h0, "R1", "after reset release",
          32'({tx_word_o, rx_word_o, serial_o, done_o}), 32'(0));
    mon_on = 1'b1;
    xfer(8'b1011_0101, 1'b0, 8'h00);
    xfer(8'h00, 1'b0, 8'h00);
    xfer(8'hFF, 1'b0, 8'h00);
    xfer(8'h80, 1'b0, 8'h00);
    xfer(8'h01, 1'b0, 8'h00);
    xfer(8'h5A, 1'b1, 8'hC3);
    xfer(8'b1011_0101, 1'b1, 8'h00);
    @(negedge clk);
    check(rx_word_o === 8'b1010_1101, "R5", "reference byte reversed",
          32'(rx_word_o), 32'(8'b1010_1101));
    check(exp_bits.size() == 0 && exp_res.size() == 0, "R6", "scoreboard drained",
          32'(exp_bits.size() + exp_res.size()), 32'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule